// File: doc/BRIEF.md
# DDR-Capture Serial Deserializer

This block receives one serial data lane whose bit rate is twice the frequency of a fast clock. It samples the lane on both edges of that clock. Rising-edge samples and falling-edge samples form two half-rate streams. The falling-edge sample is retimed through a half-cycle latch, so the two samples of each fast cycle reach the shift stage together as one aligned pair.

Each stream fills its own short left-shifting register on the fast clock. A slow system clock runs at a quarter of the fast clock and is phase-aligned with it. On each slow edge, a word register collects both shifters and interleaves them into a parallel word that the system logic reads.

The clocks are generated outside the block. Word-boundary training is also done outside. A synchronous reset clears the stored state. A clock enable freezes every register in the block.

Top module: `ddr_serial_deser`

## Requirements
- R1: The sample taken on a fast rising edge is the rising bit of a pair, and the sample taken on the following falling edge is the falling bit of the same pair. Rising bits feed the even word positions and falling bits feed the odd word positions.
- R2: On every enabled fast rising edge, each lane shifter moves its contents one place toward the most significant bit and takes in the newest pair bit at bit 0.
- R3: Output bit 2k comes from even-lane shifter bit k, and output bit 2k+1 comes from odd-lane shifter bit k. The earliest pair therefore lands in bits 7:6, with its rising bit in bit 6.
- R4: Let m be the fast rising edge that coincides with a slow rising edge. The word presented after edge m holds the pairs whose rising samples were taken on fast edges m-5 to m-2. Pair m-2-k sits in bits 2k+1:2k.
- R5: The parallel output changes only on a slow rising edge. It stays stable across the fast edges between two slow edges.
- R6: A synchronous active-high reset clears the capture registers, the shifters and the output word to zero. The output reads zero after the first slow edge that samples the reset.
- R7: While the clock enable is low, every register holds its value, and the serial input has no effect. The output word keeps the value it had before.
- R8: Reset takes priority over a low clock enable. A slow edge that samples reset high and enable low still clears the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast sampling clock, at half the serial bit rate |
| clk_slow | input | 1 | System clock, at a quarter of clk_fast and phase-aligned with it |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all registers |
| ser_in | input | 1 | Serial data lane |
| word_out | output | 8 | Parallel word, updated on the slow rising edge |

## Verification
Reset and a low clock enable can reach the word register on the same slow edge. The bench provokes this by raising reset and dropping the enable together for one slow period. It then keeps the enable low for the next slow period. The bench expects a zero word at the first slow edge and the same zero held at the next edge. A resumed stream is then checked bit for bit against pairs computed from the driven serial pattern. Those checks apply only once two clean slow periods have passed.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
package ddr_deser_pkg;
   // one fast clock cycle worth of lane data, already aligned
   typedef struct packed {
      logic rise_bit;
      logic fall_bit;
   } edge_pair_t;

   localparam int unsigned MIN_PAIRS   = 2;
   localparam int unsigned LANE_COUNT  = 2;
   localparam int unsigned LANE_RISE   = 0;
   localparam int unsigned LANE_FALL   = 1;
endpackage

// File: rtl/ddr_edge_capture.sv
`timescale 1ns/1ps
module ddr_edge_capture
   import ddr_deser_pkg::*;
#(
   parameter bit RETIME_LATCH = 1'b1
) (
   input  logic       clk_fast,
   input  logic       rst,
   input  logic       ce,
   input  logic       ser_in,
   output edge_pair_t pair_o
);

   logic rise_q;
   logic fall_q;
   logic fall_hold;

   always_ff @(posedge clk_fast) begin
      if (rst)     rise_q <= 1'b0;
      else if (ce) rise_q <= ser_in;
   end

   always_ff @(negedge clk_fast) begin
      if (rst)     fall_q <= 1'b0;
      else if (ce) fall_q <= ser_in;
   end

   generate
      if (RETIME_LATCH) begin : g_latch
         // open while the clock is low, closed across the rising edge
         always_latch begin
            if (!clk_fast) fall_hold = fall_q;
         end
      end else begin : g_direct
         assign fall_hold = fall_q;
      end
   endgenerate

   assign pair_o.rise_bit = rise_q;
   assign pair_o.fall_bit = fall_hold;

   assert_rise_cleared_R6: assert property (@(posedge clk_fast)
      rst |=> (pair_o.rise_bit == 1'b0));

   assert_rise_frozen_R7: assert property (@(posedge clk_fast) disable iff (rst)
      !ce |=> $stable(pair_o.rise_bit));

endmodule

// File: rtl/lane_shifter.sv
`timescale 1ns/1ps
module lane_shifter #(
   parameter int unsigned PAIRS = 4
) (
   input  logic             clk_fast,
   input  logic             rst,
   input  logic             ce,
   input  logic             bit_in,
   output logic [PAIRS-1:0] bits_o
);

   localparam int unsigned TOP = PAIRS - 1;

   logic [TOP:0] sh_q;

   always_ff @(posedge clk_fast) begin
      if (rst)     sh_q <= '0;
      else if (ce) sh_q <= {sh_q[TOP-1:0], bit_in};
   end

   assign bits_o = sh_q;

   assert_moves_up_R2: assert property (@(posedge clk_fast) disable iff (rst)
      ce |=> (bits_o[TOP:1] == $past(bits_o[TOP-1:0])));

   assert_lane_frozen_R7: assert property (@(posedge clk_fast) disable iff (rst)
      !ce |=> $stable(bits_o));

   assert_lane_cleared_R6: assert property (@(posedge clk_fast)
      rst |=> (bits_o == '0));

endmodule

// File: rtl/word_weaver.sv
`timescale 1ns/1ps
module word_weaver #(
   parameter int unsigned PAIRS = 4
) (
   input  logic               clk_slow,
   input  logic               rst,
   input  logic               ce,
   input  logic [PAIRS-1:0]   even_i,
   input  logic [PAIRS-1:0]   odd_i,
   output logic [2*PAIRS-1:0] word_o
);

   localparam int unsigned WORD_W = 2 * PAIRS;

   logic [WORD_W-1:0] woven;
   logic [WORD_W-1:0] word_q;

   generate
      for (genvar k = 0; k < PAIRS; k++) begin : g_weave
         assign woven[2*k]   = even_i[k];
         assign woven[2*k+1] = odd_i[k];
      end
   endgenerate

   always_ff @(posedge clk_slow) begin
      if (rst)     word_q <= '0;
      else if (ce) word_q <= woven;
   end

   assign word_o = word_q;

   assert_word_cleared_R6: assert property (@(posedge clk_slow)
      rst |=> (word_o == '0));

   assert_reset_beats_hold_R8: assert property (@(posedge clk_slow)
      (rst && !ce) |=> (word_o == '0));

   assert_word_frozen_R7: assert property (@(posedge clk_slow) disable iff (rst)
      !ce |=> $stable(word_o));

endmodule

// File: rtl/ddr_serial_deser.sv
`timescale 1ns/1ps
module ddr_serial_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned PAIRS        = 4,
   parameter bit          RETIME_LATCH = 1'b1
) (
   input  logic                 clk_fast,
   input  logic                 clk_slow,
   input  logic                 rst,
   input  logic                 ce,
   input  logic                 ser_in,
   output logic [2*PAIRS-1:0]   word_out
);

   localparam int unsigned WORD_W = 2 * PAIRS;

   generate
      if (PAIRS < MIN_PAIRS) begin : g_bad_pairs
         $error("ddr_serial_deser: PAIRS must be at least 2");
      end
   endgenerate

   edge_pair_t                   pair;
   logic [LANE_COUNT-1:0]        lane_in;
   logic [PAIRS-1:0]             lane_bits [LANE_COUNT];
   logic [WORD_W-1:0]            word;

   ddr_edge_capture #(
      .RETIME_LATCH (RETIME_LATCH)
   ) u_capture (
      .clk_fast (clk_fast),
      .rst      (rst),
      .ce       (ce),
      .ser_in   (ser_in),
      .pair_o   (pair)
   );

   assign lane_in[LANE_RISE] = pair.rise_bit;
   assign lane_in[LANE_FALL] = pair.fall_bit;

   generate
      for (genvar ln = 0; ln < LANE_COUNT; ln++) begin : g_lane
         lane_shifter #(
            .PAIRS (PAIRS)
         ) u_shift (
            .clk_fast (clk_fast),
            .rst      (rst),
            .ce       (ce),
            .bit_in   (lane_in[ln]),
            .bits_o   (lane_bits[ln])
         );
      end
   endgenerate

   word_weaver #(
      .PAIRS (PAIRS)
   ) u_weave (
      .clk_slow (clk_slow),
      .rst      (rst),
      .ce       (ce),
      .even_i   (lane_bits[LANE_RISE]),
      .odd_i    (lane_bits[LANE_FALL]),
      .word_o   (word)
   );

   assign word_out = word;

   // a rising-edge sample reaches even-lane bit 0 two fast edges later
   assert_rise_to_even_R1: assert property (@(posedge clk_fast) disable iff (rst)
      ($past(ce) && $past(ce, 2) && !$past(rst) && !$past(rst, 2))
         |-> (lane_bits[LANE_RISE][0] == $past(ser_in, 2)));

endmodule

// File: tb/ddr_serial_deser_tb.sv
`timescale 1ns/1ps
module ddr_serial_deser_tb;

   localparam int NS   = 60;
   localparam int NJ   = NS * 4 + 2;

   typedef struct {
      int         kind;   // 0 skip, 1 value, 2 hold previous
      logic [7:0] val;
      string      req;
   } exp_t;

   logic       clk_f = 1'b0;
   logic       clk_s = 1'b0;
   logic       rst   = 1'b1;
   logic       ce    = 1'b1;
   logic       ser   = 1'b0;
   logic [7:0] word_out;

   int checks   = 0;
   int failures = 0;
   bit reported = 1'b0;
   int ph       = 0;

   logic a_bits [NJ];
   logic b_bits [NJ];
   logic rst_s  [NS];
   logic ce_s   [NS];
   exp_t exp_q  [$];
   logic [7:0] last_obs = '0;

   ddr_serial_deser u_dut (
      .clk_fast (clk_f),
      .clk_slow (clk_s),
      .rst      (rst),
      .ce       (ce),
      .ser_in   (ser),
      .word_out (word_out)
   );

   // 250 MHz fast clock, slow clock at a quarter rate on the same edges
   initial begin
      forever begin
         #2;
         clk_f = 1'b1;
         if (ph == 0) clk_s = 1'b1;
         if (ph == 2) clk_s = 1'b0;
         ph = (ph + 1) % 4;
         #2;
         clk_f = 1'b0;
      end
   end

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      report();
   end

   function automatic logic rst_of(int i);
      return (i < 0) ? 1'b1 : rst_s[i];
   endfunction

   function automatic logic ce_of(int i);
      return (i < 0) ? 1'b1 : ce_s[i];
   endfunction

   task automatic push_expect(int j);
      exp_t e;
      int   q = j / 4;
      e.kind = 0; e.val = '0; e.req = "";
      if (rst_of(q - 1)) begin
         e.kind = 1;
         e.req  = ce_of(q - 1) ? "R6 reset clears word" : "R8 reset over low enable";
      end else if (!ce_of(q - 1)) begin
         e.kind = 2;
         e.req  = "R7 hold while enable low";
      end else if (!rst_of(q - 2) && ce_of(q - 2)) begin
         e.kind = 1;
         e.req  = "R1 R2 R3 R4 word content";
         for (int k = 0; k < 4; k++) begin
            e.val[2*k]   = a_bits[j - 2 - k];
            e.val[2*k+1] = b_bits[j - 2 - k];
         end
      end
      exp_q.push_back(e);
   endtask

   task automatic run_driver();
      @(posedge clk_s);
      for (int j = 0; j < NS * 4; j++) begin
         if ((j % 4 == 0) && (j > 0)) push_expect(j);
         #1;
         ser = b_bits[j];
         if (j % 4 == 0) begin
            rst = rst_s[j / 4];
            ce  = ce_s[j / 4];
         end
         #2;
         ser = a_bits[j + 1];
         @(posedge clk_f);
      end
   endtask

   task automatic run_monitor();
      forever begin
         @(posedge clk_s);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            logic [7:0] v1 = word_out;
            if (e.kind == 1) begin
               checks++;
               if (v1 !== e.val) begin
                  failures++;
                  $display("FAIL %s: actual=%02h expected=%02h", e.req, v1, e.val);
               end
            end else if (e.kind == 2) begin
               checks++;
               if (v1 !== last_obs) begin
                  failures++;
                  $display("FAIL %s: actual=%02h expected=%02h", e.req, v1, last_obs);
               end
            end
            last_obs = v1;
            #8;
            checks++;  // R5: no change at the fast edges in between
            if (word_out !== v1) begin
               failures++;
               $display("FAIL R5 stable between slow edges: actual=%02h expected=%02h",
                        word_out, v1);
            end
         end
      end
   endtask

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int j = 0; j < NJ; j++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case ((j / 48) % 5)
            1:       begin a_bits[j] = 1'b1; b_bits[j] = 1'b0; end  // 0x55 words
            2:       begin a_bits[j] = 1'b1; b_bits[j] = 1'b1; end  // 0xFF words
            3:       begin a_bits[j] = 1'b0; b_bits[j] = 1'b1; end  // 0xAA words
            default: begin a_bits[j] = lf[0]; b_bits[j] = lf[7]; end
         endcase
      end
      a_bits[0] = 1'b0;
      for (int s = 0; s < NS; s++) begin
         rst_s[s] = (s < 2) || (s == 31) || (s == 41);
         ce_s[s]  = !((s == 21) || (s == 22) || (s == 41) || (s == 42));
      end
      fork
         run_monitor();
      join_none
      run_driver();
      #40;
      report();
   end

endmodule